// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block is the interrupt front end of a small 8-bit processor core with a 16-bit address space. It looks at the interrupt inputs only when the core flags the last clock of an instruction. A non-maskable request is caught on its rising edge and held until it is served. A maskable request is honoured only while the interrupt-enable flag is set. Accepting either kind of request clears that flag.

For a maskable request, the block runs an acknowledge cycle and inserts two wait states, so a ripple priority chain among the devices has time to settle. It then latches the byte that the winning device drives on the data bus. What it does with that byte depends on a 2-bit response mode.

- In the opcode mode, the byte goes to the core as the next instruction.
- In the fixed mode, the byte is discarded and a call to 0x0038 results.
- In the table mode, the block builds an even pointer from the page register (high byte) and the vector (low byte). It reads two bytes there and forms the service address little-endian.

Calls are preceded by a one-cycle request that tells the core to push the return address. Every response ends with a one-cycle done strobe that carries the result.

Top module: `irq_resp_seq`

## Requirements
- R1: After reset (rst_n low), the interrupt-enable flag is 0, the page register is 0x00, the acknowledge, table-read, push and done outputs are 0, and the response mode is the opcode mode (code 0).
- R2: A maskable request starts an acknowledge only if `insn_end` is high while `int_en` is 1. With `int_en` at 0, or with `insn_end` low, `int_req` causes no acknowledge and no done.
- R3: The acknowledge cycle drives `ack_m1` and `ack_iorq` high for exactly three consecutive cycles (one cycle plus two wait states), starting in the cycle after the boundary. `bus_data` is latched at the end of the third cycle.
- R4: In mode code 0, done rises three cycles after the boundary edge with `resp_is_op`=1 and `resp_opcode` equal to the latched byte, and no push request is made.
- R5: In mode code 1, done rises four cycles after the boundary edge with `resp_target`=0x0038 and `resp_is_op`=0, whatever the bus byte was.
- R6: In mode code 2, the table is read at pointer P = {page register, vector[7:1], 0} and then at P+1. Done rises six cycles after the boundary edge with `resp_target` = {byte at P+1, byte at P}. The table port returns data one cycle after `tbl_rd`.
- R7: A rising edge of `nmi_req` makes the next boundary produce a call to 0x0066, regardless of the mode and of `int_en`. Done follows one cycle after the boundary edge, and no acknowledge cycle is run. Holding `nmi_req` high does not trigger a second response.
- R8: When a pending non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one is served.
- R9: Accepting any request clears `int_en`. A pulse on `ie_set` sets it.
- R10: For every call response (NMI, mode 1, mode 2), `push_ret` is high for exactly the one cycle just before done.
- R11: A mode write with code 3 is ignored and the previous mode stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_end | input | 1 | High during the last clock of an instruction |
| int_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| mode_wr | input | 1 | Write strobe for the response mode |
| mode_val | input | 2 | Mode code: 0 opcode, 1 fixed, 2 table |
| ie_set | input | 1 | Sets the interrupt-enable flag |
| ireg_wr | input | 1 | Write strobe for the page register |
| ireg_val | input | 8 | New page register value |
| ack_m1 | output | 1 | Opcode-fetch type marker of the acknowledge cycle |
| ack_iorq | output | 1 | Acknowledge request to the devices |
| bus_data | input | 8 | Vector byte driven by the device |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | 16 | Table read address |
| tbl_data | input | 8 | Table read data, one cycle after the strobe |
| push_ret | output | 1 | Core must push the return address |
| resp_done | output | 1 | One-cycle strobe: result valid |
| resp_is_op | output | 1 | 1: result is an opcode, 0: result is a call target |
| resp_target | output | 16 | Call target |
| resp_opcode | output | 8 | Opcode handed to the core |
| int_en | output | 1 | Interrupt-enable flag |
| ireg | output | 8 | Page register |

## Verification
A wrong sequencer state shows up at the ports within one cycle. It appears as an acknowledge that is too short or too long, a table read with an odd first address, a push that is not followed by done, or a done that arrives at the wrong cycle count after the boundary. A wrong captured vector or table byte only becomes visible at the done strobe, through the target or opcode value. For that reason the bench compares every response's latency, acknowledge length, push position and result against values it works out from the mode, the page register and its own model of the table. A lost or stuck enable flag or NMI latch shows as a response that is missing or unexpected at the next boundary.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK,
        S_TBL_LO,
        S_TBL_HI,
        S_PUSH,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        M_OPCODE = 2'd0,
        M_FIXED  = 2'd1,
        M_TABLE  = 2'd2
    } resp_mode_e;

    localparam logic [1:0] MODE_RESERVED = 2'd3;

endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [1:0]        mode_val,
    input  logic              ie_set,
    input  logic              ireg_wr,
    input  logic [DATA_W-1:0] ireg_val,
    input  logic              accept,
    output resp_mode_e        mode,
    output logic              ie,
    output logic [DATA_W-1:0] ireg
);

    typedef struct packed {
        resp_mode_e        mode;
        logic              ie;
        logic [DATA_W-1:0] ireg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr && (mode_val != MODE_RESERVED)) begin
            cfg_d.mode = resp_mode_e'(mode_val);
        end
        if (ie_set) begin
            cfg_d.ie = 1'b1;
        end
        // acceptance wins over a simultaneous enable
        if (accept) begin
            cfg_d.ie = 1'b0;
        end
        if (ireg_wr) begin
            cfg_d.ireg = ireg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: M_OPCODE, ie: 1'b0, ireg: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode = cfg_q.mode;
    assign ie   = cfg_q.ie;
    assign ireg = cfg_q.ireg;

endmodule

// File: rtl/irq_nmi_latch.sv
`timescale 1ns/1ps
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic take,
    output logic pend
);

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_t;

    nmi_t nmi_d, nmi_q;

    always_comb begin
        nmi_d      = nmi_q;
        nmi_d.prev = nmi_req;
        if (take) begin
            nmi_d.pend = 1'b0;
        end
        if (nmi_req && !nmi_q.prev) begin
            nmi_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q <= '0;
        end else begin
            nmi_q <= nmi_d;
        end
    end

    assign pend = nmi_q.pend;

endmodule

// File: rtl/irq_ptr_calc.sv
`timescale 1ns/1ps
module irq_ptr_calc #(
    parameter int DATA_W = 8,
    parameter int PTR_ALIGN = 2
) (
    input  logic [DATA_W-1:0]   page,
    input  logic [DATA_W-1:0]   vec,
    output logic [2*DATA_W-1:0] ptr
);

    localparam int LSB_W = $clog2(PTR_ALIGN);

    // the low bits that select a byte inside one table entry are forced to zero
    generate
        if (LSB_W > 0) begin : g_align
            assign ptr = {page, vec[DATA_W-1:LSB_W], {LSB_W{1'b0}}};
        end else begin : g_noalign
            assign ptr = {page, vec};
        end
    endgenerate

endmodule

// File: rtl/irq_resp_seq.sv
`timescale 1ns/1ps
module irq_resp_seq
    import irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WAIT_N = 2,
    parameter logic [2*DATA_W-1:0] FIX_ADDR = 16'h0038,
    parameter logic [2*DATA_W-1:0] NMI_ADDR = 16'h0066
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_end,
    input  logic                int_req,
    input  logic                nmi_req,
    input  logic                mode_wr,
    input  logic [1:0]          mode_val,
    input  logic                ie_set,
    input  logic                ireg_wr,
    input  logic [DATA_W-1:0]   ireg_val,
    output logic                ack_m1,
    output logic                ack_iorq,
    input  logic [DATA_W-1:0]   bus_data,
    output logic                tbl_rd,
    output logic [2*DATA_W-1:0] tbl_addr,
    input  logic [DATA_W-1:0]   tbl_data,
    output logic                push_ret,
    output logic                resp_done,
    output logic                resp_is_op,
    output logic [2*DATA_W-1:0] resp_target,
    output logic [DATA_W-1:0]   resp_opcode,
    output logic                int_en,
    output logic [DATA_W-1:0]   ireg
);

    localparam int ADDR_W = 2 * DATA_W;
    localparam int WCNT_W = $clog2(WAIT_N + 2);
    localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(WAIT_N);

    typedef struct packed {
        seq_state_e        st;
        logic [WCNT_W-1:0] wcnt;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] lo;
        logic              from_tbl;
        logic [ADDR_W-1:0] target;
        logic [DATA_W-1:0] opcode;
        logic              is_op;
    } seq_t;

    seq_t seq_d, seq_q;

    resp_mode_e        mode;
    logic              nmi_pend;
    logic              take_nmi;
    logic              take_int;
    logic [ADDR_W-1:0] tbl_ptr;
    logic              ack_c;
    logic              rd_c;
    logic              push_c;
    logic              done_c;
    logic [ADDR_W-1:0] addr_c;

    irq_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .ie_set   (ie_set),
        .ireg_wr  (ireg_wr),
        .ireg_val (ireg_val),
        .accept   (take_nmi | take_int),
        .mode     (mode),
        .ie       (int_en),
        .ireg     (ireg)
    );

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .take    (take_nmi),
        .pend    (nmi_pend)
    );

    irq_ptr_calc #(.DATA_W(DATA_W), .PTR_ALIGN(2)) u_ptr (
        .page (ireg),
        .vec  (bus_data),
        .ptr  (tbl_ptr)
    );

    always_comb begin
        seq_d    = seq_q;
        take_nmi = 1'b0;
        take_int = 1'b0;
        ack_c    = 1'b0;
        rd_c     = 1'b0;
        push_c   = 1'b0;
        done_c   = 1'b0;
        addr_c   = seq_q.ptr;
        unique case (seq_q.st)
            S_IDLE: begin
                if (insn_end) begin
                    if (nmi_pend) begin
                        take_nmi       = 1'b1;
                        seq_d.target   = NMI_ADDR;
                        seq_d.is_op    = 1'b0;
                        seq_d.from_tbl = 1'b0;
                        seq_d.st       = S_PUSH;
                    end else if (int_req && int_en) begin
                        take_int   = 1'b1;
                        seq_d.wcnt = '0;
                        seq_d.st   = S_ACK;
                    end
                end
            end
            S_ACK: begin
                ack_c = 1'b1;
                if (seq_q.wcnt == WCNT_LAST) begin
                    unique case (mode)
                        M_OPCODE: begin
                            seq_d.opcode = bus_data;
                            seq_d.is_op  = 1'b1;
                            seq_d.st     = S_DONE;
                        end
                        M_FIXED: begin
                            seq_d.target   = FIX_ADDR;
                            seq_d.is_op    = 1'b0;
                            seq_d.from_tbl = 1'b0;
                            seq_d.st       = S_PUSH;
                        end
                        default: begin
                            seq_d.ptr      = tbl_ptr;
                            seq_d.is_op    = 1'b0;
                            seq_d.from_tbl = 1'b1;
                            seq_d.st       = S_TBL_LO;
                        end
                    endcase
                end else begin
                    seq_d.wcnt = seq_q.wcnt + 1'b1;
                end
            end
            S_TBL_LO: begin
                rd_c     = 1'b1;
                addr_c   = seq_q.ptr;
                seq_d.st = S_TBL_HI;
            end
            S_TBL_HI: begin
                rd_c     = 1'b1;
                addr_c   = {seq_q.ptr[ADDR_W-1:1], 1'b1};
                seq_d.lo = tbl_data;
                seq_d.st = S_PUSH;
            end
            S_PUSH: begin
                push_c = 1'b1;
                if (seq_q.from_tbl) begin
                    seq_d.target = {tbl_data, seq_q.lo};
                end
                seq_d.st = S_DONE;
            end
            S_DONE: begin
                done_c   = 1'b1;
                seq_d.st = S_IDLE;
            end
            default: begin
                seq_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ack_m1      = ack_c;
    assign ack_iorq    = ack_c;
    assign tbl_rd      = rd_c;
    assign tbl_addr    = addr_c;
    assign push_ret    = push_c;
    assign resp_done   = done_c;
    assign resp_is_op  = seq_q.is_op;
    assign resp_target = seq_q.target;
    assign resp_opcode = seq_q.opcode;

endmodule

// File: rtl/irq_resp_chk.sv
`timescale 1ns/1ps
module irq_resp_chk #(
    parameter int DATA_W = 8,
    parameter int WAIT_N = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                insn_end,
    input logic                ack_iorq,
    input logic                tbl_rd,
    input logic [2*DATA_W-1:0] tbl_addr,
    input logic                push_ret,
    input logic                resp_done,
    input logic                resp_is_op,
    input logic                int_en
);

    localparam int ADDR_W = 2 * DATA_W;

    int unsigned iorq_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iorq_run <= 0;
        end else if (ack_iorq) begin
            iorq_run <= iorq_run + 1;
        end else begin
            iorq_run <= 0;
        end
    end

    // R3
    ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_iorq) |-> iorq_run == WAIT_N + 1);

    // R3
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_iorq |-> !tbl_rd && !push_ret && !resp_done);

    // R2
    ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_iorq) |-> $past(insn_end) && $past(int_en));

    // R9
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_iorq) |-> !int_en);

    // R10
    push_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_ret |=> resp_done && !resp_is_op);

    // R4
    op_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done && resp_is_op |-> !$past(push_ret));

    // R6
    tbl_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd && !$past(tbl_rd) |-> !tbl_addr[0]);

    // R6
    tbl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd && $past(tbl_rd) |-> tbl_addr == ADDR_W'($past(tbl_addr) + 1'b1));

endmodule

bind irq_resp_seq irq_resp_chk #(.DATA_W(DATA_W), .WAIT_N(WAIT_N)) u_chk (.*);

// File: tb/irq_resp_seq_test.sv
`timescale 1ns/1ps
module irq_resp_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_end = 1'b0, int_req = 1'b0, nmi_req = 1'b0;
    logic        mode_wr = 1'b0, ie_set = 1'b0, ireg_wr = 1'b0;
    logic [1:0]  mode_val = 2'd0;
    logic [7:0]  ireg_val = 8'h00, bus_data = 8'h00, tbl_q = 8'h00;
    logic        ack_m1, ack_iorq, tbl_rd, push_ret, resp_done, resp_is_op, int_en;
    logic [15:0] tbl_addr, resp_target;
    logic [7:0]  resp_opcode, ireg;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_resp_seq uut (
        .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .int_req(int_req),
        .nmi_req(nmi_req), .mode_wr(mode_wr), .mode_val(mode_val),
        .ie_set(ie_set), .ireg_wr(ireg_wr), .ireg_val(ireg_val),
        .ack_m1(ack_m1), .ack_iorq(ack_iorq), .bus_data(bus_data),
        .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_q),
        .push_ret(push_ret), .resp_done(resp_done), .resp_is_op(resp_is_op),
        .resp_target(resp_target), .resp_opcode(resp_opcode),
        .int_en(int_en), .ireg(ireg)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd7;
        return m ^ a[15:8] ^ 8'hA5;
    endfunction

    // table memory model, one cycle read latency
    always_ff @(posedge clk) begin
        if (tbl_rd) tbl_q <= mem_byte(tbl_addr);
    end

    task automatic chk(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_wr = 1'b1; mode_val = m;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic set_page(input logic [7:0] p);
        @(negedge clk); ireg_wr = 1'b1; ireg_val = p;
        @(negedge clk); ireg_wr = 1'b0;
    endtask

    task automatic enable_int();
        @(negedge clk); ie_set = 1'b1;
        @(negedge clk); ie_set = 1'b0;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
    endtask

    task automatic do_resp(input logic [7:0] v, output int lat, output logic [15:0] tgt,
                           output logic isop, output logic [7:0] op, output int nio, output int pat);
        int k;
        lat = -1; nio = 0; pat = -1; tgt = '0; isop = 1'b0; op = '0;
        @(negedge clk); insn_end = 1'b1; bus_data = v;
        @(negedge clk); insn_end = 1'b0;
        k = 0;
        while (k < 16) begin
            if (ack_iorq) nio++;
            if (push_ret) pat = k;
            if (resp_done) begin
                lat = k; tgt = resp_target; isop = resp_is_op; op = resp_opcode;
                break;
            end
            @(negedge clk);
            k++;
        end
    endtask

    // {nmi, mode, page, vector}
    localparam logic [18:0] VECS [8] = '{
        {1'b0, 2'd1, 8'h00, 8'hFF},
        {1'b0, 2'd2, 8'h12, 8'h35},
        {1'b0, 2'd0, 8'h00, 8'hCD},
        {1'b1, 2'd2, 8'h40, 8'h00},
        {1'b0, 2'd2, 8'hFF, 8'hFE},
        {1'b0, 2'd1, 8'h00, 8'h00},
        {1'b1, 2'd0, 8'h00, 8'hAA},
        {1'b0, 2'd2, 8'h00, 8'h01}
    };

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, nio, pat;
        logic [15:0] tgt;
        logic isop;
        logic [7:0] op;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 int_en", int_en == 1'b0, int_en, 0);
        chk("R1 page", ireg == 8'h00, ireg, 0);
        chk("R1 outputs idle", {ack_iorq, tbl_rd, push_ret, resp_done} == 4'b0,
            {ack_iorq, tbl_rd, push_ret, resp_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 default mode is opcode mode; R4 latency and handoff
        enable_int();
        chk("R9 ie_set", int_en == 1'b1, int_en, 1);
        int_req = 1'b1;
        do_resp(8'hC7, lat, tgt, isop, op, nio, pat);
        int_req = 1'b0;
        chk("R1 default mode opcode", isop == 1'b1 && op == 8'hC7, {isop, op}, {1'b1, 8'hC7});
        chk("R4 latency", lat == 3, lat, 3);
        chk("R4 no push", pat == -1, pat, 32'hFFFFFFFF);
        chk("R3 ack length", nio == 3, nio, 3);
        chk("R9 cleared by accept", int_en == 1'b0, int_en, 0);

        // R2 request ignored while disabled
        int_req = 1'b1;
        do_resp(8'h11, lat, tgt, isop, op, nio, pat);
        chk("R2 ignored when disabled", lat == -1 && nio == 0, nio, 0);
        // R2 request ignored without boundary
        enable_int();
        begin
            int seen = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (ack_iorq || resp_done) seen++;
            end
            chk("R2 ignored without boundary", seen == 0, seen, 0);
        end
        int_req = 1'b0;

        // table walk
        for (int i = 0; i < 8; i++) begin
            logic        v_nmi;
            logic [1:0]  v_mode;
            logic [7:0]  v_page, v_vec;
            logic [15:0] p, e_tgt;
            int e_lat;
            {v_nmi, v_mode, v_page, v_vec} = VECS[i];
            set_mode(v_mode);
            set_page(v_page);
            if (v_nmi) pulse_nmi();
            else begin
                enable_int();
                int_req = 1'b1;
            end
            do_resp(v_vec, lat, tgt, isop, op, nio, pat);
            int_req = 1'b0;
            p = {v_page, v_vec[7:1], 1'b0};
            if (v_nmi) begin
                e_lat = 1; e_tgt = 16'h0066;
                chk("R7 nmi target", !isop && tgt == e_tgt, tgt, e_tgt);
                chk("R7 nmi latency", lat == e_lat, lat, e_lat);
                chk("R7 no ack", nio == 0, nio, 0);
                chk("R10 push before done", pat == e_lat - 1, pat, e_lat - 1);
            end else if (v_mode == 2'd0) begin
                chk("R4 opcode", isop && op == v_vec, op, v_vec);
                chk("R4 latency", lat == 3, lat, 3);
                chk("R3 ack length", nio == 3, nio, 3);
            end else if (v_mode == 2'd1) begin
                chk("R5 fixed target", !isop && tgt == 16'h0038, tgt, 16'h0038);
                chk("R5 latency", lat == 4, lat, 4);
                chk("R10 push before done", pat == 3, pat, 3);
                chk("R3 ack length", nio == 3, nio, 3);
            end else begin
                e_tgt = {mem_byte(p | 16'h0001), mem_byte(p)};
                chk("R6 table target", !isop && tgt == e_tgt, tgt, e_tgt);
                chk("R6 latency", lat == 6, lat, 6);
                chk("R10 push before done", pat == 5, pat, 5);
                chk("R3 ack length", nio == 3, nio, 3);
            end
        end

        // R11 reserved mode code ignored
        set_mode(2'd1);
        set_mode(2'd3);
        enable_int();
        int_req = 1'b1;
        do_resp(8'h00, lat, tgt, isop, op, nio, pat);
        int_req = 1'b0;
        chk("R11 reserved write ignored", !isop && tgt == 16'h0038, tgt, 16'h0038);

        // R8 nmi beats int at same boundary
        set_mode(2'd2);
        enable_int();
        int_req = 1'b1;
        pulse_nmi();
        do_resp(8'h20, lat, tgt, isop, op, nio, pat);
        int_req = 1'b0;
        chk("R8 nmi priority", tgt == 16'h0066 && nio == 0, tgt, 16'h0066);
        chk("R9 cleared by nmi", int_en == 1'b0, int_en, 0);

        // R7 held level does not retrigger
        @(negedge clk); nmi_req = 1'b1;
        do_resp(8'h00, lat, tgt, isop, op, nio, pat);
        chk("R7 edge response", lat == 1 && tgt == 16'h0066, tgt, 16'h0066);
        do_resp(8'h00, lat, tgt, isop, op, nio, pat);
        chk("R7 no retrigger", lat == -1, lat, 32'hFFFFFFFF);
        nmi_req = 1'b0;

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule